// File: doc/BRIEF.md
# Multi-Channel Edge Timestamp Capture

This block timestamps the edges of external input signals, one capture input per channel. Each channel owns a 16-bit counter that advances on that channel's divided tick pulse. The counter runs only while the channel's capture-enable bit is set, and it restarts from zero each time capture is enabled again.

The raw input passes through a two-flop synchronizer. An optional inversion is applied after the synchronizer, and then the edge detector runs. A rising edge copies the counter into the channel's rise register, and a falling edge copies it into a separate fall register. Each copy sets a sticky per-channel flag and a matching bit in a shared status word. The interrupt line is raised whenever a status bit and its enable bit are both set.

Software reaches the block through a simple register port. Writes take effect on the clock edge, and read data is combinational from the address.

Top module: `ecap_unit`

Register word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | Capture enable, bit ch = channel ch | read/write |
| 1 | Interrupt enable | read/write |
| 2 | Interrupt status | write 1 to clear |
| 8 + 4·ch | Channel control | see R7 |
| 9 + 4·ch | Rise value | read only |
| 10 + 4·ch | Fall value | read only |
| 11 + 4·ch | Counter | read only |

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: While enable bit ch (address 0) is clear, counter ch is held at 0. While the bit is set, the counter adds 1 on each cycle in which `tick[ch]` is high and holds its value otherwise.
- R3: The counter wraps from 0xFFFF to 0.
- R4: A rising edge that appears on `cap_in[ch]` in cycle t is stored in the rise register at the third clock edge after t. The stored value is the counter value read two cycles after t.
- R5: A falling edge is stored in the fall register with the same timing as R4, and it leaves the rise register unchanged.
- R6: Control bit 0 (invert) swaps the two edges, so a physical falling edge is stored in the rise register.
- R7: Control bit 2 is the rise flag and bit 1 is the fall flag. Each is set by its own capture and cleared by writing 1 to it. Writing 0 to a flag leaves it unchanged.
- R8: Status bit 2·ch records rise captures and bit 2·ch+1 records fall captures. Each status bit is cleared by writing 1 to it.
- R9: `irq` is high exactly when some status bit is set whose enable bit, at the same position in address 1, is also set.
- R10: An edge that arrives while its flag is still set overwrites the stored value and leaves the flag set.
- R11: Edges on a disabled channel change no value register, no flag and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| tick | input | NUM_CH | Per-channel counter advance pulse |
| cap_in | input | NUM_CH | Asynchronous signals to be measured |
| irq | output | 1 | Capture interrupt |

## Verification
The bench measures the latency from an input transition to the stored value against the counter. A design with one synchronizer stage too few or too many stores a value that is off by one tick.

It runs one counter across the 0xFFFF boundary. This exposes a counter that saturates or is too narrow.

It covers several register-access cases:
- Clearing one flag while the other stays set, and writing zeros.
- Re-capturing while a flag is still pending.
- Masked status bits, where an interrupt that ignores its enables would show up.

It also checks the invert bit, which catches inversion applied on the wrong edge. Finally, it toggles a disabled channel to catch latching that is not gated by capture enable.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam int unsigned A_CAPEN    = 0;
    localparam int unsigned A_IEN      = 1;
    localparam int unsigned A_ISTAT    = 2;
    localparam int unsigned A_CH_BASE  = 8;
    localparam int unsigned CH_STRIDE  = 4;
    localparam int unsigned OFF_CTRL   = 0;
    localparam int unsigned OFF_RISE   = 1;
    localparam int unsigned OFF_FALL   = 2;
    localparam int unsigned OFF_CNT    = 3;

    // Per-channel control word: bit2 rise flag, bit1 fall flag, bit0 invert
    typedef struct packed {
        logic rise_flag;
        logic fall_flag;
        logic invert;
    } chan_ctrl_t;

    function automatic int unsigned ch_addr(int unsigned ch, int unsigned off);
        return A_CH_BASE + ch * CH_STRIDE + off;
    endfunction

endpackage

// File: rtl/ecap_edge.sv
module ecap_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic invert,
    output logic rise,
    output logic fall
);
    logic [SYNC_N-1:0] sync_q;
    logic              lvl;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], raw};
            prev_q <= lvl;
        end
    end

    assign lvl  = sync_q[SYNC_N-1] ^ invert;
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/ecap_chan.sv
module ecap_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             rise_ev,
    input  logic             fall_ev,
    input  logic             clr_rise,
    input  logic             clr_fall,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rise_val,
    output logic [CNT_W-1:0] fall_val,
    output logic             rise_flag,
    output logic             fall_flag,
    output logic             rise_hit,
    output logic             fall_hit
);
    assign rise_hit = rise_ev & enable;
    assign fall_hit = fall_ev & enable;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_val  <= '0;
            fall_val  <= '0;
            rise_flag <= 1'b0;
            fall_flag <= 1'b0;
        end else begin
            if (rise_hit) rise_val <= cnt;
            if (fall_hit) fall_val <= cnt;
            if (rise_hit)      rise_flag <= 1'b1;
            else if (clr_rise) rise_flag <= 1'b0;
            if (fall_hit)      fall_flag <= 1'b1;
            else if (clr_fall) fall_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ecap_unit.sv
module ecap_unit
    import ecap_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] tick,
    input  logic [NUM_CH-1:0] cap_in,
    output logic              irq
);
    localparam int ST_W = 2 * NUM_CH;

    logic [NUM_CH-1:0]             capen;
    logic [ST_W-1:0]               ien;
    logic [ST_W-1:0]               istat;
    logic [ST_W-1:0]               hit_vec;
    logic [NUM_CH-1:0]             inv;
    logic [NUM_CH-1:0]             rise_ev, fall_ev;
    logic [NUM_CH-1:0]             clr_rise, clr_fall;
    logic [NUM_CH-1:0]             rflag, fflag;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a, rise_a, fall_a;
    logic                          unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:ST_W];

    wire wr_capen = reg_we && (reg_addr == ADDR_W'(A_CAPEN));
    wire wr_ien   = reg_we && (reg_addr == ADDR_W'(A_IEN));
    wire wr_istat = reg_we && (reg_addr == ADDR_W'(A_ISTAT));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wire wr_ctrl = reg_we && (reg_addr == ADDR_W'(ch_addr(c, OFF_CTRL)));
        chan_ctrl_t wr_fields;
        assign wr_fields   = chan_ctrl_t'(reg_wdata[2:0]);
        assign clr_rise[c] = wr_ctrl && wr_fields.rise_flag;
        assign clr_fall[c] = wr_ctrl && wr_fields.fall_flag;

        always_ff @(posedge clk) begin
            if (rst)          inv[c] <= 1'b0;
            else if (wr_ctrl) inv[c] <= wr_fields.invert;
        end

        ecap_edge #(.SYNC_N(SYNC_N)) u_edge (
            .clk(clk), .rst(rst), .raw(cap_in[c]), .invert(inv[c]),
            .rise(rise_ev[c]), .fall(fall_ev[c])
        );

        ecap_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst(rst), .enable(capen[c]), .tick(tick[c]),
            .rise_ev(rise_ev[c]), .fall_ev(fall_ev[c]),
            .clr_rise(clr_rise[c]), .clr_fall(clr_fall[c]),
            .cnt(cnt_a[c]), .rise_val(rise_a[c]), .fall_val(fall_a[c]),
            .rise_flag(rflag[c]), .fall_flag(fflag[c]),
            .rise_hit(hit_vec[2*c]), .fall_hit(hit_vec[2*c+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capen <= '0;
            ien   <= '0;
            istat <= '0;
        end else begin
            if (wr_capen) capen <= reg_wdata[NUM_CH-1:0];
            if (wr_ien)   ien   <= reg_wdata[ST_W-1:0];
            istat <= (istat & ~(wr_istat ? reg_wdata[ST_W-1:0] : '0)) | hit_vec;
        end
    end

    assign irq = |(istat & ien);

    always_comb begin
        chan_ctrl_t rd_ctrl;
        reg_rdata = '0;
        rd_ctrl   = '0;
        if (reg_addr == ADDR_W'(A_CAPEN)) reg_rdata[NUM_CH-1:0] = capen;
        if (reg_addr == ADDR_W'(A_IEN))   reg_rdata[ST_W-1:0]   = ien;
        if (reg_addr == ADDR_W'(A_ISTAT)) reg_rdata[ST_W-1:0]   = istat;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(ch_addr(c, OFF_CTRL))) begin
                rd_ctrl.rise_flag = rflag[c];
                rd_ctrl.fall_flag = fflag[c];
                rd_ctrl.invert    = inv[c];
                reg_rdata[2:0]    = rd_ctrl;
            end
            if (reg_addr == ADDR_W'(ch_addr(c, OFF_RISE))) reg_rdata[CNT_W-1:0] = rise_a[c];
            if (reg_addr == ADDR_W'(ch_addr(c, OFF_FALL))) reg_rdata[CNT_W-1:0] = fall_a[c];
            if (reg_addr == ADDR_W'(ch_addr(c, OFF_CNT)))  reg_rdata[CNT_W-1:0] = cnt_a[c];
        end
    end
endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_CH-1:0]            capen,
    input logic [NUM_CH-1:0]            tick,
    input logic [2*NUM_CH-1:0]          ien,
    input logic [2*NUM_CH-1:0]          istat,
    input logic                         irq,
    input logic [NUM_CH-1:0]            rise_ev,
    input logic [NUM_CH-1:0]            fall_ev,
    input logic [NUM_CH-1:0]            rflag,
    input logic [NUM_CH-1:0]            fflag,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_a,
    input logic [NUM_CH-1:0][CNT_W-1:0] rise_a,
    input logic [NUM_CH-1:0][CNT_W-1:0] fall_a
);
    assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|ien));
    assert_irq_needs_stat_R9: assert property (@(posedge clk) disable iff (rst)
        !(|istat) |-> !irq);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
            (capen[c] && tick[c] && cnt_a[c] != {CNT_W{1'b1}})
            |=> cnt_a[c] == $past(cnt_a[c]) + CNT_W'(1));
        assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (rst)
            !capen[c] |=> cnt_a[c] == '0);
        assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (rst)
            (capen[c] && tick[c] && cnt_a[c] == {CNT_W{1'b1}}) |=> cnt_a[c] == '0);
        assert_rflag_set_R10: assert property (@(posedge clk) disable iff (rst)
            (capen[c] && rise_ev[c]) |=> rflag[c]);
        assert_fflag_set_R10: assert property (@(posedge clk) disable iff (rst)
            (capen[c] && fall_ev[c]) |=> fflag[c]);
        assert_rise_store_R4: assert property (@(posedge clk) disable iff (rst)
            (capen[c] && rise_ev[c]) |=> rise_a[c] == $past(cnt_a[c]));
        assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (rst)
            !capen[c] |=> ($stable(rise_a[c]) && $stable(fall_a[c])));
    end
endmodule

bind ecap_unit ecap_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ecap_checker (
    .clk(clk), .rst(rst), .capen(capen), .tick(tick), .ien(ien), .istat(istat),
    .irq(irq), .rise_ev(rise_ev), .fall_ev(fall_ev), .rflag(rflag), .fflag(fflag),
    .cnt_a(cnt_a), .rise_a(rise_a), .fall_a(fall_a)
);

// File: tb/ecap_unit_bench.sv
module ecap_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [NC-1:0] tick;
    logic [NC-1:0] cap_in;
    logic        irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    ecap_unit u_ecap_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .cap_in(cap_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = 6'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, v);  chk("R1 capen", v, 0);
        rd(1, v);  chk("R1 ien", v, 0);
        rd(2, v);  chk("R1 istat", v, 0);
        rd(8, v);  chk("R1 ctrl0", v, 0);
        rd(9, v);  chk("R1 rise0", v, 0);
        rd(11, v); chk("R1 cnt0", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_count;
        logic [31:0] c1, c2;
        cycles(3);
        rd(11, c1); chk("R2 cnt idle", c1, 0);
        wr(0, 32'h1);
        rd(11, c1); chk("R2 cnt start", c1, 0);
        cycles(5);
        rd(11, c2); chk("R2 cnt step", c2, c1 + 5);
        tick[0] = 1'b0;
        cycles(4);
        rd(11, c1); chk("R2 cnt hold no tick", c1, c2);
        tick[0] = 1'b1;
        wr(0, 32'h0);
        cycles(1);
        rd(11, c1); chk("R2 cnt cleared", c1, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(0, 32'h2);
        rd(15, v); chk("R3 start", v, 0);
        cycles(65535);
        rd(15, v); chk("R3 max", v, 32'hFFFF);
        cycles(1);
        rd(15, v); chk("R3 wrapped", v, 0);
        wr(0, 32'h0);
    endtask

    task automatic edge_cap(logic lvl, output logic [31:0] exp);
        logic [31:0] c;
        rd(11, c);
        cap_in[0] = lvl;
        exp = c + 2;
        cycles(3);
    endtask

    task automatic t_rise_fall;
        logic [31:0] e, v, rsave;
        wr(0, 32'h1);
        wr(1, 32'h1);
        cycles(4);
        edge_cap(1'b1, e);
        rd(9, v);  chk("R4 rise value", v, e);
        rsave = v;
        rd(8, v);  chk("R7 rise flag", v, 32'h4);
        rd(2, v);  chk("R8 status rise bit0", v, 32'h1);
        chk("R9 irq on", {31'b0, irq}, 1);
        cycles(5);
        edge_cap(1'b0, e);
        rd(10, v); chk("R5 fall value", v, e);
        rd(9, v);  chk("R5 rise untouched", v, rsave);
        rd(8, v);  chk("R7 both flags", v, 32'h6);
        rd(2, v);  chk("R8 status both", v, 32'h3);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(8, 32'h0);
        rd(8, v);  chk("R7 write0 no effect", v, 32'h6);
        wr(8, 32'h4);
        rd(8, v);  chk("R7 clear rise only", v, 32'h2);
        wr(2, 32'h1);
        rd(2, v);  chk("R8 clear bit0", v, 32'h2);
        chk("R9 masked status", {31'b0, irq}, 0);
        wr(1, 32'h2);
        chk("R9 irq fall enabled", {31'b0, irq}, 1);
        wr(2, 32'h2);
        chk("R9 irq off after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_overwrite;
        logic [31:0] e, v;
        cycles(3);
        edge_cap(1'b1, e);
        cycles(4);
        edge_cap(1'b0, e);
        rd(8, v);  chk("R10 flags set", v, 32'h6);
        cycles(7);
        edge_cap(1'b1, e);
        rd(9, v);  chk("R10 overwrite value", v, e);
        rd(8, v);  chk("R10 flag kept", v, 32'h6);
    endtask

    task automatic t_invert;
        logic [31:0] e, v, fsave;
        wr(8, 32'h7);
        cycles(3);
        wr(8, 32'h7);
        rd(8, v);  chk("R6 invert set flags clear", v, 32'h1);
        rd(10, fsave);
        cycles(3);
        edge_cap(1'b0, e);
        rd(9, v);  chk("R6 phys fall into rise", v, e);
        rd(10, v); chk("R6 fall untouched", v, fsave);
        rd(8, v);  chk("R6 rise flag only", v, 32'h5);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        wr(2, 32'hFF);
        wr(1, 32'h30);
        for (int i = 0; i < 4; i++) begin
            cap_in[2] = ~cap_in[2];
            cycles(5);
        end
        rd(17, v); chk("R11 rise2", v, 0);
        rd(18, v); chk("R11 fall2", v, 0);
        rd(16, v); chk("R11 ctrl2", v, 0);
        rd(2, v);  chk("R11 status ch2", v & 32'h30, 0);
        chk("R11 irq", {31'b0, irq}, 0);
    endtask

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        tick = '1; cap_in = '0;
        cycles(3);
        rst = 1'b0;
        cycles(1);
        t_reset();
        t_count();
        t_wrap();
        t_rise_fall();
        t_clear();
        t_overwrite();
        t_invert();
        t_disabled();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule